// File: doc/BRIEF.md
# Floppy Spindle Motor Timeout Controller

This block runs the spindle motor line of a floppy drive. A one-cycle access request turns the motor on when it is off. The block then waits a spin-up time before it signals that reads and writes may begin. The heads load together with the motor, so the block has no separate head-load output.

The spin-up wait comes from a strap bit, which selects either a very short wait or a long wait of about one second. Once the motor is up to speed, the block watches for accesses. If no access arrives for about three seconds, it switches the motor off.

All timing counts a prescaled tick input, nominally one pulse per millisecond. The short wait, the long wait and the idle limit are parameters given in ticks.

Top module: `fdd_motor_ctrl`

## Requirements
- R1: After reset `motor_on_no` is 1 (motor off), `spun_up_o` is 0 and `idle_o` is 0.
- R2: When the motor is off, a cycle with `req_i` high drives `motor_on_no` low from the next clock edge, with `spun_up_o` still 0. `spun_up_o` is never 1 while `motor_on_no` is 1.
- R3: The spin-up wait is SHORT_TICKS ticks when `mode_long_i` is 0 and LONG_TICKS ticks when it is 1. `spun_up_o` rises on the clock edge that samples the last tick of the wait, counting from the edge that turned the motor on.
- R4: `mode_long_i` is captured on the request that turns the motor on. Changing it during spin-up has no effect on the length of the wait.
- R5: A request that arrives during spin-up does not restart or lengthen the wait.
- R6: When the motor is up to speed, a request leaves `spun_up_o` high and the motor on, and restarts the idle count, so `idle_o` is 0 after that edge.
- R7: When the motor is up to speed, the edge that samples the IDLE_TICKS-th consecutive tick without `req_i` or `busy_i` turns the motor off (`motor_on_no` goes to 1) and clears `spun_up_o`.
- R8: While `busy_i` is high, the idle count is held at zero, so the motor stays on for any number of ticks.
- R9: `idle_o` is 1 only while the motor is up to speed and at least one tick has been counted since the last access. It is 0 otherwise.
- R10: Only cycles with `tick_i` high advance the spin-up and idle counts. Cycles without a tick change neither `spun_up_o` nor the motor state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle time base pulse (nominally 1 ms) |
| req_i | input | 1 | One-cycle drive access request |
| busy_i | input | 1 | Level, high while an access is in progress |
| mode_long_i | input | 1 | Strap: 0 selects the short spin-up wait, 1 selects the long wait |
| motor_on_no | output | 1 | Spindle motor enable, active low |
| spun_up_o | output | 1 | Spin-up done; transfers may start |
| idle_o | output | 1 | Motor running with at least one quiet tick counted |

## Verification
The hardest case to reach from the ports is an idle timeout that lands right around an access. A request or a rise of the busy level must arrive on or just before the tick that would switch the motor off. Only a long quiet stretch with accurate tick counting gets there. The stimulus alternates random phases of dense and very sparse requests, so timeouts fire often and sometimes collide with a late request. Directed sequences reach the exact last-tick boundaries of the spin-up and idle counts.

// File: rtl/fdd_motor_pkg.sv
package fdd_motor_pkg;
  typedef enum logic [1:0] {
    MOT_OFF  = 2'd0,
    MOT_SPIN = 2'd1,
    MOT_RUN  = 2'd2
  } mot_state_e;
endpackage

// File: rtl/fdd_tick_cnt.sv
module fdd_tick_cnt #(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (tick_i)  cnt_q <= cnt_q + CNT_W'(1);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/fdd_motor_seq.sv
module fdd_motor_seq
  import fdd_motor_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic       mode_long_i,
  input  logic       spin_done_i,
  input  logic       idle_done_i,
  output mot_state_e state_o,
  output logic       mode_long_o
);
  mot_state_e state_q, state_d;
  logic       mode_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      MOT_OFF:  if (req_i)       state_d = MOT_SPIN;
      MOT_SPIN: if (spin_done_i) state_d = MOT_RUN;
      MOT_RUN:  if (idle_done_i) state_d = MOT_OFF;
      default:                   state_d = MOT_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= MOT_OFF;
      mode_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      // strap sampled only on the turn-on request
      if (state_q == MOT_OFF && req_i) mode_q <= mode_long_i;
    end
  end

  assign state_o     = state_q;
  assign mode_long_o = mode_q;
endmodule

// File: rtl/fdd_motor_ctrl.sv
module fdd_motor_ctrl
  import fdd_motor_pkg::*;
#(
  parameter int IDLE_TICKS  = 3000,
  parameter int LONG_TICKS  = 1000,
  parameter int SHORT_TICKS = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic req_i,
  input  logic busy_i,
  input  logic mode_long_i,
  output logic motor_on_no,
  output logic spun_up_o,
  output logic idle_o
);
  localparam int MAX_SPIN = (LONG_TICKS > SHORT_TICKS) ? LONG_TICKS : SHORT_TICKS;
  localparam int MAX_T    = (IDLE_TICKS > MAX_SPIN) ? IDLE_TICKS : MAX_SPIN;
  localparam int CNT_W    = $clog2(MAX_T + 1);
  localparam logic [CNT_W-1:0] IDLE_END  = CNT_W'(IDLE_TICKS - 1);
  localparam logic [CNT_W-1:0] LONG_END  = CNT_W'(LONG_TICKS - 1);
  localparam logic [CNT_W-1:0] SHORT_END = CNT_W'(SHORT_TICKS - 1);

  mot_state_e       state;
  logic             mode_long;
  logic             spin_clr, idle_clr, access;
  logic             spin_done, idle_done;
  logic [CNT_W-1:0] spin_cnt, idle_cnt, spin_end;

  assign access   = req_i | busy_i;
  assign spin_clr = (state != MOT_SPIN);
  assign idle_clr = (state != MOT_RUN) | access;
  assign spin_end = mode_long ? LONG_END : SHORT_END;

  assign spin_done = tick_i & (state == MOT_SPIN) & (spin_cnt == spin_end);
  assign idle_done = tick_i & ~idle_clr & (idle_cnt == IDLE_END);

  fdd_tick_cnt #(.CNT_W(CNT_W)) u_spin_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (spin_clr),
    .tick_i (tick_i),
    .cnt_o  (spin_cnt)
  );

  fdd_tick_cnt #(.CNT_W(CNT_W)) u_idle_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (idle_clr),
    .tick_i (tick_i),
    .cnt_o  (idle_cnt)
  );

  fdd_motor_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .mode_long_i (mode_long_i),
    .spin_done_i (spin_done),
    .idle_done_i (idle_done),
    .state_o     (state),
    .mode_long_o (mode_long)
  );

  assign motor_on_no = (state == MOT_OFF);
  assign spun_up_o   = (state == MOT_RUN);
  assign idle_o      = (state == MOT_RUN) & (idle_cnt != '0);
endmodule

// File: rtl/fdd_motor_ctrl_chk.sv
module fdd_motor_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tick_i,
  input logic req_i,
  input logic busy_i,
  input logic motor_on_no,
  input logic spun_up_o,
  input logic idle_o
);
  // R2
  a_r2_req_starts_motor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (motor_on_no && req_i) |=> !motor_on_no);
  a_r2_spun_needs_motor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spun_up_o |-> !motor_on_no);
  a_r2_turn_on_not_spun: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(motor_on_no) |-> !spun_up_o);
  // R3 / R10
  a_r3_spinup_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(spun_up_o) |-> $past(tick_i));
  // R6
  a_r6_req_keeps_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spun_up_o && req_i) |=> (spun_up_o && !idle_o));
  // R8
  a_r8_busy_keeps_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spun_up_o && busy_i) |=> (spun_up_o && !idle_o));
  // R7
  a_r7_off_after_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(spun_up_o) |-> (motor_on_no && $past(tick_i && !req_i && !busy_i)));
  // R9
  a_r9_idle_only_spun: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o |-> spun_up_o);
endmodule

bind fdd_motor_ctrl fdd_motor_ctrl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick_i      (tick_i),
  .req_i       (req_i),
  .busy_i      (busy_i),
  .motor_on_no (motor_on_no),
  .spun_up_o   (spun_up_o),
  .idle_o      (idle_o)
);

// File: tb/fdd_motor_ctrl_test.sv
`timescale 1ns/1ps
module fdd_motor_ctrl_test;
  localparam int IDLE  = 25;
  localparam int LONGT = 12;
  localparam int SHORT = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, req = 1'b0, busy = 1'b0, mode = 1'b0;
  logic motor_on_n, spun, idle;

  int checks = 0;
  int failures = 0;
  bit cmp_en = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  fdd_motor_ctrl #(.IDLE_TICKS(IDLE), .LONG_TICKS(LONGT), .SHORT_TICKS(SHORT)) uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .req_i(req), .busy_i(busy),
    .mode_long_i(mode), .motor_on_no(motor_on_n), .spun_up_o(spun), .idle_o(idle)
  );

  // reference model from the requirements: 0 off, 1 spin, 2 run
  int m_st, m_cnt, m_lim;

  function automatic int next_lim(bit m);
    return m ? LONGT : SHORT;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st <= 0; m_cnt <= 0; m_lim <= SHORT;
    end else begin
      case (m_st)
        0: if (req) begin m_st <= 1; m_cnt <= 0; m_lim <= next_lim(mode); end
        1: if (tick) begin
             if (m_cnt == m_lim - 1) begin m_st <= 2; m_cnt <= 0; end
             else m_cnt <= m_cnt + 1;
           end
        default: if (req || busy) m_cnt <= 0;
           else if (tick) begin
             if (m_cnt == IDLE - 1) begin m_st <= 0; m_cnt <= 0; end
             else m_cnt <= m_cnt + 1;
           end
      endcase
    end
  end

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en && rst_n) begin
      check("R2 motor_on_no vs model", motor_on_n, m_st == 0);
      check("R3 spun_up_o vs model", spun, m_st == 2);
      check("R9 idle_o vs model", idle, (m_st == 2) && (m_cnt != 0));
    end
  end

  task automatic do_ticks(int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1; @(negedge clk);
      tick = 1'b0; @(negedge clk);
    end
  endtask

  task automatic pulse_req();
    req = 1'b1; @(negedge clk); req = 1'b0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        failures++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
      end
    end
  end

  initial begin
    int dens;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 motor off in reset", motor_on_n, 1'b1);
    check("R1 spun low in reset", spun, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 motor off after reset", motor_on_n, 1'b1);
    check("R1 spun low after reset", spun, 1'b0);
    check("R1 idle low after reset", idle, 1'b0);
    cmp_en = 1'b1;

    // short wait; mode change and request during spin-up
    mode = 1'b0;
    pulse_req();
    check("R2 motor on after req", motor_on_n, 1'b0);
    check("R2 not spun at turn-on", spun, 1'b0);
    mode = 1'b1;
    do_ticks(1);
    pulse_req();
    repeat (10) @(negedge clk);
    check("R10 no tick no spin-up", spun, 1'b0);
    do_ticks(SHORT - 2);
    check("R3 not spun before last tick", spun, 1'b0);
    do_ticks(1);
    check("R3 spun after short wait", spun, 1'b1);
    check("R4 R5 wait kept short", motor_on_n, 1'b0);
    check("R9 idle low at spin-up", idle, 1'b0);
    do_ticks(1);
    check("R9 idle after quiet tick", idle, 1'b1);
    do_ticks(IDLE - 3);
    check("R7 still on before limit", spun, 1'b1);
    pulse_req();
    check("R6 req passes, stays spun", spun, 1'b1);
    check("R6 idle restarted", idle, 1'b0);
    do_ticks(IDLE - 1);
    check("R6 count restarted by req", spun, 1'b1);
    busy = 1'b1;
    do_ticks(IDLE * 2);
    check("R8 busy holds motor", spun, 1'b1);
    check("R8 idle low while busy", idle, 1'b0);
    busy = 1'b0;
    do_ticks(IDLE - 1);
    check("R7 on one tick before limit", motor_on_n, 1'b0);
    do_ticks(1);
    check("R7 motor off at limit", motor_on_n, 1'b1);
    check("R7 spun cleared at limit", spun, 1'b0);

    // long wait; mode dropped during spin-up
    mode = 1'b1;
    pulse_req();
    mode = 1'b0;
    do_ticks(LONGT - 1);
    check("R4 long wait not yet done", spun, 1'b0);
    do_ticks(1);
    check("R3 spun after long wait", spun, 1'b1);
    do_ticks(IDLE);
    check("R7 long run times out", motor_on_n, 1'b1);

    // random phases, dense and sparse requests
    for (int ph = 0; ph < 8; ph++) begin
      dens = (ph % 2 == 0) ? 10 : 400;
      for (int c = 0; c < 900; c++) begin
        tick = ($urandom % 3) == 0;
        req  = ($urandom % dens) == 0;
        if (($urandom % 40) == 0) busy = ($urandom % 3) == 0;
        mode = $urandom % 2;
        @(negedge clk);
      end
      busy = 1'b0;
    end
    req = 1'b0; tick = 1'b0;
    @(negedge clk);
    done = 1'b1;
    finish_run();
  end
endmodule